// File: doc/BRIEF.md
# ECC Check-Bit Error Injector

This block sits on the write path into ECC-protected memory and damages the stored check bits on purpose, so that the error detection and reporting logic further down the line can be tested with known faults. Each write carries two sections, a low and a high half, and each section has eight check bits and one parity bit. The decoded location of the write arrives already split into six fields: module, rank, channel, bank, page and column. A small register interface programs a match pattern, a check-bit mask, a section selection, an injection type and an arm control.

When the block is armed and the write location matches every field that is not a wildcard, the block changes the check bits and parity of the selected sections in the same cycle as the write. The check bits are XORed with the mask and one parity bit is inverted in each selected section. A one-shot injection disarms itself after the first corruption. A repeating injection keeps corrupting matching writes until software disarms it.

Top module: `ecc_inject_top`

## Requirements
- R1: After reset the arm register reads 0, type, section and mask read 0, and each of the six match registers reads 0x8000_0000 (wildcard set, value 0).
- R2: Register map: 0x0 arm, 0x1 type in bits [2:0], 0x2 section in bits [1:0], 0x3 mask in bits [7:0], 0x8+i match field i (0 module, 1 rank, 2 channel, 3 bank, 4 page, 5 column) with value in bits [15:0] and wildcard in bit 31. Every register reads back what was written, and match value bits above the field width (2,2,1,3,16,10) read as 0.
- R3: A write matches when, for every field, the wildcard bit is set or the field input equals the stored value. Each field's wildcard is independent of the others.
- R4: With type bit 1 (ECC) set, a matching armed write leaves chk_out equal to chk_in XOR the mask in each selected section. With bit 1 clear, the check bits pass unchanged.
- R5: Section bit 0 selects the low check byte chk[7:0] and parity bit par[0]. Bit 1 selects chk[15:8] and par[1]. So value 1 affects the low half, 2 the high half, 3 both, and 0 neither.
- R6: With type bit 2 (parity) set, a matching armed write inverts exactly one parity bit per selected section.
- R7: With both bit 1 and bit 2 set, the ECC and parity corruption are applied in the same write.
- R8: With type bit 0 (repeat) clear, the arm register reads 0 after the first matching armed write, and later matching writes pass unchanged.
- R9: With type bit 0 set, every matching armed write is corrupted and the arm stays set until software writes 0 to it.
- R10: Nothing is corrupted and inj_fire stays 0 while wr_valid is 0, while the block is disarmed, or when any non-wildcard field mismatches. Outputs are combinational from the inputs and add no cycle.
- R11: Writing any nonzero value to the arm register arms it, and it then reads back 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr (combinational) |
| wr_valid | input | 1 | A memory write is present this cycle |
| wr_dimm | input | 2 | Decoded module index |
| wr_rank | input | 2 | Decoded rank |
| wr_chan | input | 1 | Decoded channel |
| wr_bank | input | 3 | Decoded bank |
| wr_page | input | 16 | Decoded page |
| wr_col | input | 10 | Decoded column |
| chk_in | input | 16 | Check bits from the encoder, low section in [7:0] |
| par_in | input | 2 | Parity bit per section |
| chk_out | output | 16 | Check bits to memory, possibly corrupted |
| par_out | output | 2 | Parity bits to memory, possibly corrupted |
| inj_fire | output | 1 | Injection applied to this write |

## Verification
A stored match value or wildcard in the wrong state shows up on the first write at a location that tests that field. Such a write either corrupts bits it should leave alone or leaves clean bits it should corrupt, and the bench checks chk_out and par_out in the same cycle. A wrong arm state shows on the next write after an injection: with one-shot the second write must pass clean, and with repeat it must still be corrupted. The arm register is also read back directly one cycle after that write. Section and type faults show at once as a wrong byte or parity bit, because every section and type combination is swept.

// File: rtl/ecc_inject_pkg.sv
package ecc_inject_pkg;

    localparam int NUM_FIELDS = 6;
    localparam int FIELD_MAXW = 16;

    typedef struct packed {
        logic par;
        logic ecc;
        logic rpt;
    } inj_type_t;

endpackage

// File: rtl/ecc_inject_regs.sv
module ecc_inject_regs
    import ecc_inject_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 32,
    parameter int CHK_W  = 8,
    parameter int NSECT  = 2
) (
    input  logic                                   clk,
    input  logic                                   rst_n,
    input  logic                                   reg_we,
    input  logic [ADDR_W-1:0]                      reg_addr,
    input  logic [DATA_W-1:0]                      reg_wdata,
    output logic [DATA_W-1:0]                      reg_rdata,
    input  logic [NUM_FIELDS-1:0][FIELD_MAXW-1:0]  fw_mask,
    input  logic                                   fire,
    output logic                                   arm,
    output inj_type_t                              typ,
    output logic [NSECT-1:0]                       sect,
    output logic [CHK_W-1:0]                       mask,
    output logic [NUM_FIELDS-1:0]                  wild,
    output logic [NUM_FIELDS-1:0][FIELD_MAXW-1:0]  val
);

    localparam int FIDX_W = $clog2(NUM_FIELDS + 1);
    localparam logic [FIDX_W-1:0] NF_L = FIDX_W'(NUM_FIELDS);
    localparam logic [ADDR_W-1:0] A_ARM  = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] A_TYPE = ADDR_W'(1);
    localparam logic [ADDR_W-1:0] A_SECT = ADDR_W'(2);
    localparam logic [ADDR_W-1:0] A_MASK = ADDR_W'(3);

    typedef struct packed {
        logic                                  arm;
        inj_type_t                             typ;
        logic [NSECT-1:0]                      sect;
        logic [CHK_W-1:0]                      mask;
        logic [NUM_FIELDS-1:0]                 wild;
        logic [NUM_FIELDS-1:0][FIELD_MAXW-1:0] val;
    } state_t;

    state_t st_d, st_q;

    logic              is_fld;
    logic [FIDX_W-1:0] fidx;

    always_comb begin
        fidx   = reg_addr[FIDX_W-1:0];
        is_fld = reg_addr[ADDR_W-1] && (fidx < NF_L)
                 && (reg_addr[ADDR_W-2:0] == (ADDR_W-1)'(fidx));
    end

    always_comb begin
        st_d = st_q;
        if (fire && !st_q.typ.rpt) begin
            st_d.arm = 1'b0;
        end
        if (reg_we) begin
            if (reg_addr == A_ARM) begin
                st_d.arm = |reg_wdata;
            end else if (reg_addr == A_TYPE) begin
                st_d.typ = reg_wdata[2:0];
            end else if (reg_addr == A_SECT) begin
                st_d.sect = reg_wdata[NSECT-1:0];
            end else if (reg_addr == A_MASK) begin
                st_d.mask = reg_wdata[CHK_W-1:0];
            end else if (is_fld) begin
                st_d.val[fidx]  = reg_wdata[FIELD_MAXW-1:0] & fw_mask[fidx];
                st_d.wild[fidx] = reg_wdata[DATA_W-1];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.wild <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        reg_rdata = '0;
        if (reg_addr == A_ARM) begin
            reg_rdata[0] = st_q.arm;
        end else if (reg_addr == A_TYPE) begin
            reg_rdata[2:0] = st_q.typ;
        end else if (reg_addr == A_SECT) begin
            reg_rdata[NSECT-1:0] = st_q.sect;
        end else if (reg_addr == A_MASK) begin
            reg_rdata[CHK_W-1:0] = st_q.mask;
        end else if (is_fld) begin
            reg_rdata[FIELD_MAXW-1:0] = st_q.val[fidx];
            reg_rdata[DATA_W-1]       = st_q.wild[fidx];
        end
    end

    assign arm  = st_q.arm;
    assign typ  = st_q.typ;
    assign sect = st_q.sect;
    assign mask = st_q.mask;
    assign wild = st_q.wild;
    assign val  = st_q.val;

    // R8
    oneshot_disarm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && !st_q.typ.rpt && !reg_we) |=> !st_q.arm);

    // R9
    repeat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && st_q.typ.rpt && !reg_we) |=> st_q.arm);

    // R11
    arm_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_addr == A_ARM && (|reg_wdata)) |=> st_q.arm);

endmodule

// File: rtl/ecc_inject_match.sv
module ecc_inject_match
    import ecc_inject_pkg::*;
(
    input  logic                                   wr_valid,
    input  logic                                   arm,
    input  logic [NUM_FIELDS-1:0][FIELD_MAXW-1:0]  fld,
    input  logic [NUM_FIELDS-1:0]                  wild,
    input  logic [NUM_FIELDS-1:0][FIELD_MAXW-1:0]  val,
    output logic                                   fire
);

    logic [NUM_FIELDS-1:0] hit;

    for (genvar i = 0; i < NUM_FIELDS; i++) begin : g_fld
        assign hit[i] = wild[i] || (fld[i] == val[i]);
    end

    assign fire = wr_valid && arm && (&hit);

endmodule

// File: rtl/ecc_inject_corrupt.sv
module ecc_inject_corrupt
    import ecc_inject_pkg::*;
#(
    parameter int CHK_W = 8,
    parameter int NSECT = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     fire,
    input  inj_type_t                typ,
    input  logic [NSECT-1:0]         sect,
    input  logic [CHK_W-1:0]         mask,
    input  logic [NSECT*CHK_W-1:0]   chk_in,
    input  logic [NSECT-1:0]         par_in,
    output logic [NSECT*CHK_W-1:0]   chk_out,
    output logic [NSECT-1:0]         par_out
);

    for (genvar s = 0; s < NSECT; s++) begin : g_sect
        logic hit_ecc, hit_par;
        assign hit_ecc = fire && typ.ecc && sect[s];
        assign hit_par = fire && typ.par && sect[s];
        assign chk_out[s*CHK_W +: CHK_W] = chk_in[s*CHK_W +: CHK_W]
                                           ^ (hit_ecc ? mask : '0);
        assign par_out[s] = par_in[s] ^ hit_par;
    end

    // R10
    idle_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !fire |-> (chk_out == chk_in && par_out == par_in));

    // R5
    low_untouched_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sect[0] |-> (chk_out[CHK_W-1:0] == chk_in[CHK_W-1:0] && par_out[0] == par_in[0]));

    // R6
    par_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !typ.par |-> (par_out == par_in));

    // R4
    ecc_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !typ.ecc |-> (chk_out == chk_in));

endmodule

// File: rtl/ecc_inject_top.sv
module ecc_inject_top
    import ecc_inject_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 32,
    parameter int CHK_W  = 8,
    parameter int NSECT  = 2,
    parameter int DIMM_W = 2,
    parameter int RANK_W = 2,
    parameter int CHAN_W = 1,
    parameter int BANK_W = 3,
    parameter int PAGE_W = 16,
    parameter int COL_W  = 10
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    reg_we,
    input  logic [ADDR_W-1:0]       reg_addr,
    input  logic [DATA_W-1:0]       reg_wdata,
    output logic [DATA_W-1:0]       reg_rdata,
    input  logic                    wr_valid,
    input  logic [DIMM_W-1:0]       wr_dimm,
    input  logic [RANK_W-1:0]       wr_rank,
    input  logic [CHAN_W-1:0]       wr_chan,
    input  logic [BANK_W-1:0]       wr_bank,
    input  logic [PAGE_W-1:0]       wr_page,
    input  logic [COL_W-1:0]        wr_col,
    input  logic [NSECT*CHK_W-1:0]  chk_in,
    input  logic [NSECT-1:0]        par_in,
    output logic [NSECT*CHK_W-1:0]  chk_out,
    output logic [NSECT-1:0]        par_out,
    output logic                    inj_fire
);

    logic [NUM_FIELDS-1:0][FIELD_MAXW-1:0] fld, fw_mask, val;
    logic [NUM_FIELDS-1:0]                 wild;
    logic                                  arm, fire;
    inj_type_t                             typ;
    logic [NSECT-1:0]                      sect;
    logic [CHK_W-1:0]                      mask;

    assign fld[0] = FIELD_MAXW'(wr_dimm);
    assign fld[1] = FIELD_MAXW'(wr_rank);
    assign fld[2] = FIELD_MAXW'(wr_chan);
    assign fld[3] = FIELD_MAXW'(wr_bank);
    assign fld[4] = FIELD_MAXW'(wr_page);
    assign fld[5] = FIELD_MAXW'(wr_col);

    for (genvar i = 0; i < NUM_FIELDS; i++) begin : g_fw
        localparam int FW = (i == 0) ? DIMM_W : (i == 1) ? RANK_W :
                            (i == 2) ? CHAN_W : (i == 3) ? BANK_W :
                            (i == 4) ? PAGE_W : COL_W;
        assign fw_mask[i] = FIELD_MAXW'((1 << FW) - 1);
    end

    ecc_inject_regs #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CHK_W(CHK_W), .NSECT(NSECT)
    ) i_regs (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .fw_mask(fw_mask),
        .fire(fire), .arm(arm), .typ(typ), .sect(sect), .mask(mask),
        .wild(wild), .val(val)
    );

    ecc_inject_match i_match (
        .wr_valid(wr_valid), .arm(arm), .fld(fld), .wild(wild), .val(val),
        .fire(fire)
    );

    ecc_inject_corrupt #(
        .CHK_W(CHK_W), .NSECT(NSECT)
    ) i_corrupt (
        .clk(clk), .rst_n(rst_n), .fire(fire), .typ(typ), .sect(sect),
        .mask(mask), .chk_in(chk_in), .par_in(par_in), .chk_out(chk_out),
        .par_out(par_out)
    );

    assign inj_fire = fire;

endmodule

// File: tb/test_ecc_inject_top.sv
`timescale 1ns/100ps
module test_ecc_inject_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        wr_valid = 1'b0;
    logic [15:0] fv [6];
    logic [15:0] chk_in = '0;
    logic [1:0]  par_in = '0;
    logic [15:0] chk_out;
    logic [1:0]  par_out;
    logic        inj_fire;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // bench model of programmed state
    bit          m_arm;
    logic [2:0]  m_typ;
    logic [1:0]  m_sect;
    logic [7:0]  m_mask;
    bit          m_wild [6];
    logic [15:0] m_val [6];
    int          fwid [6] = '{2, 2, 1, 3, 16, 10};

    always #2.5 clk = ~clk;

    ecc_inject_top i_ecc_inject_top (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .wr_valid(wr_valid),
        .wr_dimm(fv[0][1:0]), .wr_rank(fv[1][1:0]), .wr_chan(fv[2][0:0]),
        .wr_bank(fv[3][2:0]), .wr_page(fv[4]), .wr_col(fv[5][9:0]),
        .chk_in(chk_in), .par_in(par_in), .chk_out(chk_out),
        .par_out(par_out), .inj_fire(inj_fire)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic rwrite(logic [3:0] a, logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk); #1;
        reg_we = 1'b0;
        if (a == 4'h0) m_arm = (d != 0);
        else if (a == 4'h1) m_typ = d[2:0];
        else if (a == 4'h2) m_sect = d[1:0];
        else if (a == 4'h3) m_mask = d[7:0];
        else if (a >= 4'h8 && a < 4'he) begin
            m_val[a-8]  = d[15:0] & 16'((32'd1 << fwid[a-8]) - 1);
            m_wild[a-8] = d[31];
        end
    endtask

    task automatic rread(string req, logic [3:0] a, logic [31:0] exp);
        @(negedge clk);
        reg_addr = a;
        #1;
        check(req, reg_rdata, exp);
    endtask

    task automatic set_field(int f, bit w, logic [15:0] v);
        rwrite(4'(8 + f), {w, 15'd0, v});
    endtask

    // memory write: drive, compare in the same cycle, model state update
    task automatic mwrite(string req, bit valid, logic [15:0] ck, logic [1:0] pr);
        bit          hit;
        logic [15:0] ec;
        logic [1:0]  ep;
        @(negedge clk);
        wr_valid = valid; chk_in = ck; par_in = pr;
        hit = valid && m_arm;
        for (int i = 0; i < 6; i++)
            if (!m_wild[i] && (fv[i] & 16'((32'd1 << fwid[i]) - 1)) != m_val[i]) hit = 0;
        ec = ck; ep = pr;
        if (hit) begin
            for (int s = 0; s < 2; s++) begin
                if (m_sect[s] && m_typ[1]) ec[s*8 +: 8] = ec[s*8 +: 8] ^ m_mask;
                if (m_sect[s] && m_typ[2]) ep[s] = ~ep[s];
            end
        end
        #1;
        check(req, {31'd0, inj_fire}, {31'd0, hit});
        check(req, {16'd0, chk_out}, {16'd0, ec});
        check(req, {30'd0, par_out}, {30'd0, ep});
        @(posedge clk); #1;
        wr_valid = 1'b0;
        if (hit && !m_typ[0]) m_arm = 0;
    endtask

    initial begin
        #(5.0 * 100000);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 6; i++) begin fv[i] = '0; m_wild[i] = 1; m_val[i] = '0; end
        m_arm = 0; m_typ = 0; m_sect = 0; m_mask = 0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset values
        rread("R1", 4'h0, 32'h0);
        rread("R1", 4'h1, 32'h0);
        rread("R1", 4'h2, 32'h0);
        rread("R1", 4'h3, 32'h0);
        for (int i = 0; i < 6; i++) rread("R1", 4'(8 + i), 32'h8000_0000);

        // R2 readback with width masking
        rwrite(4'h1, 32'h5); rread("R2", 4'h1, 32'h5);
        rwrite(4'h2, 32'h2); rread("R2", 4'h2, 32'h2);
        rwrite(4'h3, 32'h3c); rread("R2", 4'h3, 32'h3c);
        for (int i = 0; i < 6; i++) begin
            set_field(i, 1'b0, 16'hffff);
            rread("R2", 4'(8 + i), 32'((32'd1 << fwid[i]) - 1));
            set_field(i, 1'b1, 16'h0);
            rread("R2", 4'(8 + i), 32'h8000_0000);
        end

        // R11 arm on any nonzero value
        rwrite(4'h0, 32'h100);
        rread("R11", 4'h0, 32'h1);

        // R3 per-field sweep, repeat+ECC, both sections
        rwrite(4'h1, 32'h3); rwrite(4'h2, 32'h3); rwrite(4'h3, 32'ha5);
        for (int f = 0; f < 6; f++) begin
            int lim;
            lim = (fwid[f] > 3) ? 8 : (1 << fwid[f]);
            set_field(f, 1'b0, 16'(1 % (1 << fwid[f])));
            for (int t = 0; t < lim; t++) begin
                fv[f] = 16'(t);
                mwrite("R3", 1'b1, 16'h1234, 2'b00);
            end
            fv[f] = 16'h0;
            set_field(f, 1'b1, 16'h0);
        end
        // all fields specific, each mismatching in turn
        for (int i = 0; i < 6; i++) begin set_field(i, 1'b0, 16'(1)); fv[i] = 16'(1); end
        mwrite("R3", 1'b1, 16'hbeef, 2'b01);
        for (int i = 0; i < 6; i++) begin
            fv[i] = 16'(0);
            mwrite("R3", 1'b1, 16'hbeef, 2'b01);
            fv[i] = 16'(1);
        end

        // R4 R5 R6 R7 sweep section x type, repeat kept
        for (int s = 0; s < 4; s++) begin
            for (int t = 0; t < 4; t++) begin
                rwrite(4'h2, 32'(s));
                rwrite(4'h1, 32'((t << 1) | 1));
                rwrite(4'h3, 32'(8'h11 * (s + t + 1)));
                mwrite((t == 3) ? "R7" : (t == 2) ? "R6" : (t == 1) ? "R4" : "R5",
                       1'b1, 16'h0f0f ^ 16'(s * 257 + t), 2'(t));
            end
        end

        // R10 no valid / disarmed
        mwrite("R10", 1'b0, 16'haaaa, 2'b10);
        rwrite(4'h0, 32'h0);
        mwrite("R10", 1'b1, 16'haaaa, 2'b10);

        // R8 one-shot
        rwrite(4'h1, 32'h6); rwrite(4'h2, 32'h3); rwrite(4'h3, 32'hff);
        rwrite(4'h0, 32'h1);
        mwrite("R8", 1'b1, 16'h5555, 2'b00);
        rread("R8", 4'h0, 32'h0);
        mwrite("R8", 1'b1, 16'h5555, 2'b00);

        // R9 repeat until cleared
        rwrite(4'h1, 32'h3); rwrite(4'h0, 32'h1);
        for (int k = 0; k < 3; k++) mwrite("R9", 1'b1, 16'(k * 4369), 2'b11);
        rread("R9", 4'h0, 32'h1);
        rwrite(4'h0, 32'h0);
        mwrite("R9", 1'b1, 16'h7777, 2'b11);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule